// File: doc/BRIEF.md
# Refill-On-Read Random Word FIFO

This block buffers 64-bit random words in a FIFO and keeps the FIFO topped up from an internal word producer. A small control register sets the operating mode. In the deterministic and conditioned modes, a fixed-latency conditioner stub delivers one word per request. In raw mode, a sampler collects eight consecutive 8-bit samples from one selected group of eight oscillator inputs and delivers one word every eight cycles.

Every word taken out of the FIFO leaves room that the producer fills again. The producer starts a new word only while the stored words plus the one in flight are fewer than the depth, so the FIFO never overfills. Words leave through single-word loads or through bursts that present one word per cycle and end with a done pulse. A read from an empty FIFO returns zero and raises a sticky underflow flag.

Top module: `rand_word_fifo`

## Requirements
- R1: After synchronous reset, `level` is 0, `mode` is 0, and `underflow`, `rd_valid` and `burst_done` are 0.
- R2: In the control word, bit 0 is unit reset, bit 1 is FIFO enable, bit 2 is entropy enable, bit 3 is expose-raw and bits 4 and up select the oscillator group. The cycle after a write without bit 0, `mode` reads as follows:
  - 0 (off) when bit 1 is clear.
  - 1 (deterministic) when bit 1 is set and bit 2 is clear.
  - 2 (conditioned) when bits 1 and 2 are set and bit 3 is clear.
  - 3 (raw) when bits 1, 2 and 3 are all set.
- R3: A control write with bit 0 set empties the FIFO, turns the mode off, and clears both `underflow` and the conditioner word counter, whatever the other bits hold.
- R4: `level` never exceeds DEPTH. While the mode is not off, the producer refills the FIFO until it is full and then stays idle. While the mode is off, no word is added.
- R5: Each word read from a full FIFO is replaced. In deterministic mode, `level` returns to DEPTH COND_LAT+1 cycles after the read edge.
- R6: In deterministic and conditioned modes, the producer starts one cycle after there is room. The word enters the FIFO COND_LAT cycles after it starts. A deterministic word is {~s[31:0], s[31:0]}, where s counts the conditioner words delivered since the last unit reset.
- R7: A conditioned word is the deterministic word XORed with the XOR of all 64-bit slices of `ro_in`.
- R8: In raw mode, group g is `ro_in[8g+7:8g]`. A word holds eight consecutive samples of that group, with the first sample in bits 63:56. Words arrive back to back, one every 8 cycles, with the first 9 cycles after the mode write.
- R9: A `ld_req` pops the oldest word. It appears on `rd_data` with `rd_valid` one cycle later, and words come out in the order they were stored.
- R10: Bursts:
  - `burst_go` with length N yields min(N, BURST_MAX) words on consecutive cycles, starting two cycles after the request.
  - `burst_done` pulses alone on the cycle after the last word. A length of 0 gives only the pulse.
  - `ld_req` is ignored in the request cycle and while a burst is active.
- R11: A read from an empty FIFO returns zero, leaves `level` at 0 and sets `underflow`. The flag stays set until reset or a unit reset.
- R12: A control write without bit 0 discards the word in production and keeps the stored words. Production then restarts under the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | CTL_W | Control word |
| ro_in | input | RO_COUNT | Oscillator sample inputs |
| ld_req | input | 1 | Single-word load request |
| burst_go | input | 1 | Burst read request |
| burst_len | input | 7 | Requested burst length (below 128) |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 64 | Read word |
| burst_done | output | 1 | Burst completion pulse |
| level | output | LVL_W | Words currently stored |
| mode | output | 2 | Decoded operating mode |
| underflow | output | 1 | Sticky empty-read flag |

## Verification
The bench builds the block with a depth of 8 words, a burst cap of 4 and a conditioner latency of 6 cycles, keeping 128 oscillator inputs. The small depth lets a complete fill, the full-and-idle state, a drain and an empty read all happen within a few hundred cycles. The cap of 4 makes a request for 10 words exercise truncation. The short latency makes exact cycle counts on fill, refill and restart-after-rewrite cheap to check.

// File: rtl/rwf_pkg.sv
package rwf_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_DET  = 2'd1,
    MODE_COND = 2'd2,
    MODE_RAW  = 2'd3
  } rwf_mode_e;

  localparam int unsigned CB_RST    = 0;
  localparam int unsigned CB_FIFO   = 1;
  localparam int unsigned CB_ENT    = 2;
  localparam int unsigned CB_RAW    = 3;
  localparam int unsigned CB_GSEL   = 4;

  localparam int unsigned WORD_W    = 64;
  localparam int unsigned SAMPLE_W  = 8;
  localparam int unsigned RAW_BEATS = WORD_W / SAMPLE_W;
  localparam int unsigned LEN_W     = 7;

  function automatic rwf_mode_e decode_mode(input logic fifo_en,
                                            input logic ent_en,
                                            input logic raw_en);
    if (!fifo_en)     return MODE_OFF;
    else if (!ent_en) return MODE_DET;
    else if (!raw_en) return MODE_COND;
    else              return MODE_RAW;
  endfunction

endpackage

// File: rtl/rwf_ctrl.sv
module rwf_ctrl
  import rwf_pkg::*;
#(
  parameter int GSEL_W = 4,
  localparam int CTL_W = CB_GSEL + GSEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic              flush,
  output rwf_mode_e         mode,
  output logic [GSEL_W-1:0] gsel
);

  logic fifo_en_q, ent_en_q, raw_en_q;
  logic [GSEL_W-1:0] gsel_q;

  assign flush = ctl_we && ctl_wdata[CB_RST];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      fifo_en_q <= 1'b0;
      ent_en_q  <= 1'b0;
      raw_en_q  <= 1'b0;
      gsel_q    <= '0;
    end else if (ctl_we) begin
      fifo_en_q <= ctl_wdata[CB_FIFO];
      ent_en_q  <= ctl_wdata[CB_ENT];
      raw_en_q  <= ctl_wdata[CB_RAW];
      gsel_q    <= ctl_wdata[CB_GSEL +: GSEL_W];
    end
  end

  assign mode = decode_mode(fifo_en_q, ent_en_q, raw_en_q);
  assign gsel = gsel_q;

endmodule

// File: rtl/rwf_producer.sv
module rwf_producer
  import rwf_pkg::*;
#(
  parameter int RO_COUNT = 128,
  parameter int COND_LAT = 81,
  parameter int DEPTH    = 64,
  localparam int GSEL_W  = $clog2(RO_COUNT / SAMPLE_W),
  localparam int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              abort,
  input  rwf_mode_e         mode,
  input  logic [GSEL_W-1:0] gsel,
  input  logic [RO_COUNT-1:0] ro_in,
  input  logic [LVL_W-1:0]  level,
  output logic              push,
  output logic [WORD_W-1:0] push_data
);

  localparam int LAT_MAX = (COND_LAT > RAW_BEATS) ? COND_LAT : RAW_BEATS;
  localparam int CNT_W   = $clog2(LAT_MAX);
  localparam int FOLD_N  = RO_COUNT / WORD_W;
  localparam int SHR_W   = WORD_W - SAMPLE_W;

  logic               busy_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [31:0]        seq_q;
  logic [SHR_W-1:0]   shr_q;
  logic [CNT_W-1:0]   last_cnt;
  logic [SAMPLE_W-1:0] grp_now;
  logic [WORD_W-1:0]  fold;
  logic [WORD_W-1:0]  cond_word;
  logic               room, start;

  // Pick the eight oscillator bits of the selected group
  assign grp_now = ro_in[{gsel, 3'b000} +: SAMPLE_W];

  // XOR all 64-bit slices of the oscillator inputs together
  logic [WORD_W-1:0] fold_chain [FOLD_N+1];
  assign fold_chain[0] = '0;
  for (genvar gi = 0; gi < FOLD_N; gi++) begin : g_fold
    assign fold_chain[gi+1] = fold_chain[gi] ^ ro_in[gi*WORD_W +: WORD_W];
  end
  assign fold = fold_chain[FOLD_N];

  assign last_cnt = (mode == MODE_RAW) ? CNT_W'(RAW_BEATS - 1) : CNT_W'(COND_LAT - 1);
  assign push     = busy_q && (cnt_q == last_cnt) && !abort;

  // Room accounting counts the word in flight as already stored
  assign room  = busy_q ? ((level + LVL_W'(1)) < LVL_W'(DEPTH)) : (level < LVL_W'(DEPTH));
  assign start = (mode != MODE_OFF) && !abort && (!busy_q || push) && room;

  assign cond_word = {~seq_q, seq_q} ^ ((mode == MODE_COND) ? fold : '0);
  assign push_data = (mode == MODE_RAW) ? {shr_q, grp_now} : cond_word;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      seq_q  <= '0;
      shr_q  <= '0;
    end else begin
      if (busy_q) shr_q <= {shr_q[SHR_W-SAMPLE_W-1:0], grp_now};
      if (push && (mode != MODE_RAW)) seq_q <= seq_q + 32'd1;
      if (abort) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (push) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q  <= cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/rwf_store.sv
module rwf_store
  import rwf_pkg::*;
#(
  parameter int DEPTH   = 64,
  localparam int AW     = $clog2(DEPTH),
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              pop,
  output logic [WORD_W-1:0] rd_data,
  output logic [LVL_W-1:0]  level,
  output logic              underflow
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr_q, rptr_q;
  logic [LVL_W-1:0]  level_q;
  logic [WORD_W-1:0] rdq;
  logic              empty_rd_q;
  logic              is_empty, pop_ok;

  assign is_empty = (level_q == '0);
  assign pop_ok   = pop && !is_empty;

  // Memory write port without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (pop) rdq <= mem[rptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr_q     <= '0;
      rptr_q     <= '0;
      level_q    <= '0;
      underflow  <= 1'b0;
      empty_rd_q <= 1'b0;
    end else begin
      if (push)   wptr_q <= wptr_q + AW'(1);
      if (pop_ok) rptr_q <= rptr_q + AW'(1);
      case ({push, pop_ok})
        2'b10:   level_q <= level_q + LVL_W'(1);
        2'b01:   level_q <= level_q - LVL_W'(1);
        default: level_q <= level_q;
      endcase
      if (pop) empty_rd_q <= is_empty;
      if (pop && is_empty) underflow <= 1'b1;
    end
  end

  assign rd_data = empty_rd_q ? '0 : rdq;
  assign level   = level_q;

endmodule

// File: rtl/rwf_reader.sv
module rwf_reader
  import rwf_pkg::*;
#(
  parameter int BURST_MAX = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_req,
  input  logic             burst_go,
  input  logic [LEN_W-1:0] burst_len,
  output logic             pop,
  output logic             rd_valid,
  output logic             burst_done,
  output logic             active
);

  localparam logic [LEN_W-1:0] CAP = LEN_W'(BURST_MAX);

  logic [LEN_W-1:0] rem_q;
  logic [LEN_W-1:0] eff_len;

  assign eff_len = (burst_len > CAP) ? CAP : burst_len;
  assign pop     = (active && (rem_q != '0)) || (ld_req && !burst_go && !active);

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      rem_q      <= '0;
      rd_valid   <= 1'b0;
      burst_done <= 1'b0;
    end else begin
      rd_valid   <= pop;
      burst_done <= active && (rem_q == '0);
      if (!active) begin
        if (burst_go) begin
          active <= 1'b1;
          rem_q  <= eff_len;
        end
      end else if (rem_q == '0) begin
        active <= 1'b0;
      end else begin
        rem_q  <= rem_q - LEN_W'(1);
      end
    end
  end

endmodule

// File: rtl/rand_word_fifo.sv
module rand_word_fifo
  import rwf_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int BURST_MAX = 32,
  parameter int COND_LAT  = 81,
  parameter int RO_COUNT  = 128,
  localparam int GSEL_W   = $clog2(RO_COUNT / 8),
  localparam int CTL_W    = 4 + GSEL_W,
  localparam int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ctl_we,
  input  logic [CTL_W-1:0]    ctl_wdata,
  input  logic [RO_COUNT-1:0] ro_in,
  input  logic                ld_req,
  input  logic                burst_go,
  input  logic [6:0]          burst_len,
  output logic                rd_valid,
  output logic [63:0]         rd_data,
  output logic                burst_done,
  output logic [LVL_W-1:0]    level,
  output logic [1:0]          mode,
  output logic                underflow
);

  logic              flush;
  rwf_mode_e         mode_w;
  logic [GSEL_W-1:0] gsel;
  logic              push, pop, rd_busy;
  logic [WORD_W-1:0] push_data;

  rwf_ctrl #(.GSEL_W(GSEL_W)) u_ctrl (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .flush(flush), .mode(mode_w), .gsel(gsel)
  );

  rwf_producer #(.RO_COUNT(RO_COUNT), .COND_LAT(COND_LAT), .DEPTH(DEPTH)) u_prod (
    .clk(clk), .rst(rst), .flush(flush), .abort(ctl_we), .mode(mode_w),
    .gsel(gsel), .ro_in(ro_in), .level(level), .push(push), .push_data(push_data)
  );

  rwf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .flush(flush), .push(push), .push_data(push_data),
    .pop(pop), .rd_data(rd_data), .level(level), .underflow(underflow)
  );

  rwf_reader #(.BURST_MAX(BURST_MAX)) u_reader (
    .clk(clk), .rst(rst), .ld_req(ld_req), .burst_go(burst_go),
    .burst_len(burst_len), .pop(pop), .rd_valid(rd_valid),
    .burst_done(burst_done), .active(rd_busy)
  );

  assign mode = mode_w;

endmodule

// File: rtl/rwf_checker.sv
module rwf_checker #(
  parameter int DEPTH = 64,
  parameter int LVL_W = 7,
  parameter int CTL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ctl_we,
  input logic [CTL_W-1:0] ctl_wdata,
  input logic             ld_req,
  input logic             burst_go,
  input logic             rd_busy,
  input logic             rd_valid,
  input logic [63:0]      rd_data,
  input logic             burst_done,
  input logic [LVL_W-1:0] level,
  input logic [1:0]       mode,
  input logic             underflow
);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH));

  p_off_no_fill_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |=> !(level > $past(level)));

  p_raw_decode_r2: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && !ctl_wdata[0] && (ctl_wdata[3:1] == 3'b111)) |=> (mode == 2'd3));

  p_unit_reset_r3: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_wdata[0]) |=> (level == '0 && mode == 2'd0 && !underflow));

  p_uflow_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (underflow && !(ctl_we && ctl_wdata[0])) |=> underflow);

  p_empty_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (level == '0 && ld_req && !burst_go && !rd_busy && !ctl_we)
      |=> (rd_valid && rd_data == 64'd0 && underflow));

  p_done_alone_r10: assert property (@(posedge clk) disable iff (rst)
    burst_done |-> !rd_valid);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    burst_done |=> !burst_done);

endmodule

bind rand_word_fifo rwf_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W), .CTL_W(CTL_W)) u_rwf_chk (
  .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .ld_req(ld_req), .burst_go(burst_go), .rd_busy(rd_busy),
  .rd_valid(rd_valid), .rd_data(rd_data), .burst_done(burst_done),
  .level(level), .mode(mode), .underflow(underflow)
);

// File: tb/test_rand_word_fifo.sv
`timescale 1ns/1ps
module test_rand_word_fifo;

  localparam int DEPTH = 8;
  localparam int BMAX  = 4;
  localparam int LAT   = 6;
  localparam int ROC   = 128;
  localparam int CTL_W = 8;
  localparam int LVL_W = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst;
  logic             ctl_we;
  logic [CTL_W-1:0] ctl_wdata;
  logic [ROC-1:0]   ro_in;
  logic             ld_req, burst_go;
  logic [6:0]       burst_len;
  logic             rd_valid, burst_done, underflow;
  logic [63:0]      rd_data;
  logic [LVL_W-1:0] level;
  logic [1:0]       mode;

  rand_word_fifo #(.DEPTH(DEPTH), .BURST_MAX(BMAX), .COND_LAT(LAT), .RO_COUNT(ROC)) i_rand_word_fifo (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ro_in(ro_in),
    .ld_req(ld_req), .burst_go(burst_go), .burst_len(burst_len),
    .rd_valid(rd_valid), .rd_data(rd_data), .burst_done(burst_done),
    .level(level), .mode(mode), .underflow(underflow)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit ended   = 0;
  string cur_req = "R9";
  logic [63:0] expq [$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] detw(input int s);
    logic [31:0] v = s[31:0];
    return {~v, v};
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Scoreboard monitor: compares every presented word with the queue head
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (expq.size() == 0) check(1'b0, cur_req, rd_data, 64'hx);
      else begin
        logic [63:0] e;
        e = expq.pop_front();
        check(rd_data === e, cur_req, rd_data, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_write(input logic [7:0] v);
    ctl_wdata = v; ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic load(input logic [63:0] e);
    expq.push_back(e);
    ld_req = 1'b1;
    @(negedge clk);
    ld_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    rst = 1'b1; ctl_we = 1'b0; ctl_wdata = '0; ro_in = '0;
    ld_req = 1'b0; burst_go = 1'b0; burst_len = '0;
    tick(4); rst = 1'b0; tick(1);

    // R1 reset state
    check(level == 0, "R1", 64'(level), 0);
    check(mode == 0 && !underflow, "R1", {mode, underflow}, 0);
    check(!rd_valid && !burst_done, "R1", {rd_valid, burst_done}, 0);

    // R2 / R6 deterministic mode, first word latency
    ctl_write(8'h02);
    check(mode == 2'd1, "R2", 64'(mode), 1);
    tick(LAT);
    check(level == 0, "R6", 64'(level), 0);
    tick(1);
    check(level == 1, "R6", 64'(level), 1);
    tick(60);
    check(level == DEPTH, "R4", 64'(level), DEPTH);
    tick(20);
    check(level == DEPTH, "R4", 64'(level), DEPTH);

    // R9 single load and R5 refill after the read
    cur_req = "R9";
    load(detw(0));
    check(level == DEPTH - 1, "R9", 64'(level), DEPTH - 1);
    tick(LAT);
    check(level == DEPTH - 1, "R5", 64'(level), DEPTH - 1);
    tick(1);
    check(level == DEPTH, "R5", 64'(level), DEPTH);

    // Turn off: stored words (seq 1..8) stay
    ctl_write(8'h00);
    check(mode == 2'd0, "R2", 64'(mode), 0);
    tick(10);
    check(level == DEPTH, "R4", 64'(level), DEPTH);

    // R10 burst of 10 capped to BMAX, loads held high are ignored
    cur_req = "R10";
    for (int s = 1; s <= BMAX; s++) expq.push_back(detw(s));
    burst_len = 7'd10; burst_go = 1'b1; ld_req = 1'b1;
    @(negedge clk);
    burst_go = 1'b0;
    check(!rd_valid, "R10", 64'(rd_valid), 0);
    for (int i = 0; i < BMAX; i++) begin
      @(negedge clk);
      check(rd_valid, "R10", 64'(rd_valid), 1);
    end
    @(negedge clk);
    check(burst_done && !rd_valid, "R10", {burst_done, rd_valid}, 2'b10);
    ld_req = 1'b0;
    @(negedge clk);
    check(level == DEPTH - BMAX && !burst_done, "R10", 64'(level), DEPTH - BMAX);

    // R10 zero-length burst
    burst_len = 7'd0; burst_go = 1'b1;
    @(negedge clk);
    burst_go = 1'b0;
    @(negedge clk);
    check(burst_done && !rd_valid, "R10", {burst_done, rd_valid}, 2'b10);
    @(negedge clk);
    check(level == DEPTH - BMAX, "R10", 64'(level), DEPTH - BMAX);

    // R10 burst of 3, in stored order
    for (int s = 5; s <= 7; s++) expq.push_back(detw(s));
    burst_len = 7'd3; burst_go = 1'b1;
    @(negedge clk);
    burst_go = 1'b0;
    tick(5);
    check(level == 1, "R10", 64'(level), 1);
    check(expq.size() == 0, "R10", 64'(expq.size()), 0);

    // R11 empty read
    cur_req = "R9";
    load(detw(8));
    cur_req = "R11";
    load(64'd0);
    check(underflow && level == 0, "R11", {underflow, 64'(level)}, 1);
    tick(3);
    check(underflow, "R11", 64'(underflow), 1);

    // R3 unit reset with every other bit set
    ctl_write(8'h0F);
    check(level == 0 && mode == 0 && !underflow, "R3", {64'(level), mode, underflow}, 0);

    // R12 rewrite during production restarts it
    ctl_write(8'h02);
    tick(2);
    ctl_write(8'h02);
    tick(LAT);
    check(level == 0, "R12", 64'(level), 0);
    tick(1);
    check(level == 1, "R12", 64'(level), 1);
    cur_req = "R12";
    load(detw(0));
    ctl_write(8'h01);

    // R7 conditioned word
    ro_in = {64'h0123_4567_89AB_CDEF, 64'h1357_9BDF_2468_ACE0};
    ctl_write(8'h06);
    check(mode == 2'd2, "R2", 64'(mode), 2);
    tick(LAT);
    check(level == 0, "R6", 64'(level), 0);
    tick(1);
    check(level == 1, "R6", 64'(level), 1);
    cur_req = "R7";
    load(detw(0) ^ 64'h0123_4567_89AB_CDEF ^ 64'h1357_9BDF_2468_ACE0);
    ctl_write(8'h01);

    // R8 raw mode, group 5 then group 10
    for (int g = 0; g < ROC / 8; g++) ro_in[g*8 +: 8] = {4'(g), ~4'(g)};
    ctl_write(8'h5E);
    check(mode == 2'd3, "R2", 64'(mode), 3);
    tick(8);
    check(level == 0, "R8", 64'(level), 0);
    tick(1);
    check(level == 1, "R8", 64'(level), 1);
    tick(8);
    check(level == 2, "R8", 64'(level), 2);
    ctl_write(8'hAE);
    cur_req = "R8";
    load({8{8'h5A}});
    load({8{8'h5A}});
    tick(12);
    load({8{8'hA5}});
    tick(2);
    check(expq.size() == 0, "R8", 64'(expq.size()), 0);

    finish_run();
  end

endmodule